// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register store of a 32-bit RISC core that runs in several privilege modes. It holds sixteen general registers as the program sees them, with the last one serving as the program counter. Which physical storage sits behind registers 8 to 14 depends on the current mode. The fast-interrupt mode has its own copies of all seven of these registers. The other four privileged modes (interrupt, supervisor, abort, undefined) each have their own copies of only registers 13 and 14. The user and system modes share the base set.

The block also holds the current status word: the four condition flags, the two interrupt masks and the 5-bit mode field. It holds one saved status word for each privileged mode. The core reads two registers at a time and writes one. A mode-change request sets the mode field. A status-write port updates the flag field or the control field of the current or the saved status word. An exception-entry request does all of the following in one clock:
- switches to the target mode;
- saves the old status word in the target mode's saved status word;
- masks normal interrupts;
- loads the return address into the target mode's register 14 and the vector into the program counter;
- raises a one-cycle pipeline-refill request.

Top module: `banked_regfile`

## Requirements
- R1: Every mode write (mode-change request, control-field status write, exception entry) stores the given 5-bit code with bit 4 forced to 1. The mode codes are user 0x10, fast-interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F.
- R2: In fast-interrupt mode, registers 8 to 14 use private storage. Writing them there leaves the values seen from user mode unchanged, and the reverse also holds.
- R3: Interrupt, supervisor, abort and undefined modes each have private registers 13 and 14. Registers 0 to 12 and 15 are shared with user mode.
- R4: User and system modes see one and the same register set. Neither mode has a saved status word.
- R5: In user or system mode, `saved_word_o` equals `status_word_o`, and a status write aimed at the saved word changes nothing.
- R6: Exception entry sets the mode to the target, sets the interrupt mask, and keeps the fast-interrupt mask and the flags. It copies the previous status word into the target's saved status word, unless the target is user or system.
- R7: Exception entry writes `exc_ret_addr` into the target mode's register 14 and `exc_vector` with bits 1:0 cleared into register 15. `refill_o` is high in exactly the cycle after an entry.
- R8: After reset the mode is supervisor (0x13), both interrupt masks are set, the flags are clear, and every register and saved word reads 0. `status_word_o` is 0x000000D3.
- R9: A control-field write to the current status word in user mode changes neither the mode nor the masks. A flag-field write in the same request still takes effect.
- R10: Reads are combinational through the current mode. A mode change committed at one clock edge is seen by reads in the following cycle.
- R11: Any write to register 15 stores the value with bits 1:0 cleared.
- R12: When requests arrive in the same cycle, the priority is exception entry first, then mode change, then status write. During an exception entry the general write is dropped. Otherwise the general write goes to the bank of the mode in force before the edge.

Status word layout: N bit 31, Z bit 30, C bit 29, V bit 28, interrupt mask bit 7, fast-interrupt mask bit 6, mode bits 4:0. All other bits read 0. The flag field is bits 31:28. The control field is bits 7:0, of which bits 7, 6 and 4:0 are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_sel | input | 4 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_sel | input | 4 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write strobe |
| wr_sel | input | 4 | Register number to write |
| wr_data | input | 32 | Write data |
| mode_chg_en | input | 1 | Mode-change request |
| mode_chg_to | input | 5 | Requested mode code |
| psr_wr_en | input | 1 | Status-word write request |
| psr_wr_saved | input | 1 | 1 selects the saved word of the current mode, 0 the current word |
| psr_wr_flags | input | 1 | Update the flag field |
| psr_wr_ctrl | input | 1 | Update the control field |
| psr_wr_data | input | 32 | Status value to write |
| exc_en | input | 1 | Exception-entry request |
| exc_mode | input | 5 | Target mode of the exception |
| exc_vector | input | 32 | Vector address loaded into register 15 |
| exc_ret_addr | input | 32 | Return address loaded into register 14 of the target |
| mode_o | output | 5 | Current mode code |
| flags_o | output | 4 | Flags {N,Z,C,V} |
| irq_mask_o | output | 1 | Interrupt mask |
| fiq_mask_o | output | 1 | Fast-interrupt mask |
| status_word_o | output | 32 | Current status word |
| saved_word_o | output | 32 | Saved status word of the current mode, or the current word in user/system |
| refill_o | output | 1 | Pipeline-refill request after exception entry |

## Verification
A wrong bank index shows up on the first read of registers 8 to 14 after a mode change, one cycle after the edge. It appears as a value that belongs to another mode, or as a write from one mode leaking into another. A corrupt status or saved word shows up at once on `status_word_o` and `saved_word_o`, and a misplaced exception save shows up when the saved word is read in the target mode. Mixing directed mode round-trips with random sequences of writes, mode changes, status writes and exceptions checks every read against a bank model on the cycle after each edge.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

    localparam int WORD_W  = 32;
    localparam int N_PHYS  = 31;   // 16 shared + 7 fast + 4 x 2 privileged
    localparam int PHYS_W  = $clog2(N_PHYS);
    localparam int N_SAVED = 5;
    localparam int SLOT_W  = $clog2(N_SAVED);

    localparam logic [4:0] MODE_USR = 5'h10;
    localparam logic [4:0] MODE_FIQ = 5'h11;
    localparam logic [4:0] MODE_IRQ = 5'h12;
    localparam logic [4:0] MODE_SVC = 5'h13;
    localparam logic [4:0] MODE_ABT = 5'h17;
    localparam logic [4:0] MODE_UND = 5'h1B;
    localparam logic [4:0] MODE_SYS = 5'h1F;
    localparam logic [4:0] MODE_MSB = 5'h10;

    typedef struct packed {
        logic       n;
        logic       z;
        logic       c;
        logic       v;
        logic       irq_off;
        logic       fiq_off;
        logic [4:0] mode;
    } status_t;

    // Physical slot behind an architectural register in a given mode.
    function automatic logic [PHYS_W-1:0] phys_idx(logic [4:0] m, logic [3:0] a);
        logic [PHYS_W-1:0] base;
        if (a < 4'd8 || a == 4'd15)
            return PHYS_W'(a);
        if (m == MODE_FIQ)
            return PHYS_W'(16) + PHYS_W'(a - 4'd8);
        if (a < 4'd13)
            return PHYS_W'(a);
        case (m)
            MODE_IRQ: base = PHYS_W'(23);
            MODE_SVC: base = PHYS_W'(25);
            MODE_ABT: base = PHYS_W'(27);
            MODE_UND: base = PHYS_W'(29);
            default:  return PHYS_W'(a);
        endcase
        return base + PHYS_W'(a == 4'd14);
    endfunction

    function automatic logic has_saved(logic [4:0] m);
        return (m == MODE_FIQ) || (m == MODE_IRQ) || (m == MODE_SVC) ||
               (m == MODE_ABT) || (m == MODE_UND);
    endfunction

    function automatic logic [SLOT_W-1:0] saved_slot(logic [4:0] m);
        case (m)
            MODE_IRQ: return SLOT_W'(1);
            MODE_SVC: return SLOT_W'(2);
            MODE_ABT: return SLOT_W'(3);
            MODE_UND: return SLOT_W'(4);
            default:  return SLOT_W'(0);
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(status_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[WORD_W-1] = s.n;
        w[WORD_W-2] = s.z;
        w[WORD_W-3] = s.c;
        w[WORD_W-4] = s.v;
        w[7]        = s.irq_off;
        w[6]        = s.fiq_off;
        w[4:0]      = s.mode;
        return w;
    endfunction

    function automatic status_t merge_status(status_t s, logic [WORD_W-1:0] w,
                                             logic do_flags, logic do_ctrl);
        status_t r;
        r = s;
        if (do_flags) begin
            r.n = w[WORD_W-1];
            r.z = w[WORD_W-2];
            r.c = w[WORD_W-3];
            r.v = w[WORD_W-4];
        end
        if (do_ctrl) begin
            r.irq_off = w[7];
            r.fiq_off = w[6];
            r.mode    = w[4:0] | MODE_MSB;
        end
        return r;
    endfunction

endpackage

// File: rtl/bankrf_gpr.sv
module bankrf_gpr
    import bankrf_pkg::*;
#(
    parameter int N_RD     = 2,
    parameter int PC_ALIGN = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [4:0]                   mode_i,
    input  logic [N_RD-1:0][3:0]         rd_sel_i,
    output logic [N_RD-1:0][WORD_W-1:0]  rd_data_o,
    input  logic                         wr_en_i,
    input  logic [3:0]                   wr_sel_i,
    input  logic [WORD_W-1:0]            wr_data_i,
    input  logic                         exc_en_i,
    input  logic [4:0]                   exc_mode_i,
    input  logic [WORD_W-1:0]            exc_vec_i,
    input  logic [WORD_W-1:0]            exc_ret_i
);

    localparam logic [WORD_W-1:0] ALIGN_MASK = {{(WORD_W-PC_ALIGN){1'b1}}, {PC_ALIGN{1'b0}}};
    localparam logic [3:0]        PC_REG     = 4'd15;
    localparam logic [3:0]        LINK_REG   = 4'd14;

    logic [WORD_W-1:0] phys_q [N_PHYS];
    logic [WORD_W-1:0] wr_val;
    logic [4:0]        exc_tgt;

    assign exc_tgt = exc_mode_i | MODE_MSB;
    assign wr_val  = (wr_sel_i == PC_REG) ? (wr_data_i & ALIGN_MASK) : wr_data_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_PHYS; i++) phys_q[i] <= '0;
        end else if (exc_en_i) begin
            phys_q[phys_idx(exc_tgt, LINK_REG)] <= exc_ret_i;
            phys_q[phys_idx(exc_tgt, PC_REG)]   <= exc_vec_i & ALIGN_MASK;
        end else if (wr_en_i) begin
            phys_q[phys_idx(mode_i, wr_sel_i)] <= wr_val;
        end
    end

    for (genvar g = 0; g < N_RD; g++) begin : g_rd
        assign rd_data_o[g] = phys_q[phys_idx(mode_i, rd_sel_i[g])];
    end

endmodule

// File: rtl/bankrf_status.sv
module bankrf_status
    import bankrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_en_i,
    input  logic [4:0]        exc_mode_i,
    input  logic              mode_chg_en_i,
    input  logic [4:0]        mode_chg_to_i,
    input  logic              psr_wr_en_i,
    input  logic              psr_wr_saved_i,
    input  logic              psr_wr_flags_i,
    input  logic              psr_wr_ctrl_i,
    input  logic [WORD_W-1:0] psr_wr_data_i,
    output status_t           cur_o,
    output logic [WORD_W-1:0] saved_word_o,
    output logic              refill_o
);

    status_t            cur_q;
    status_t            saved_q [N_SAVED];
    logic               refill_q;
    logic [4:0]         exc_tgt;
    logic               cur_has_saved;
    logic [SLOT_W-1:0]  cur_slot;

    assign exc_tgt       = exc_mode_i | MODE_MSB;
    assign cur_has_saved = has_saved(cur_q.mode);
    assign cur_slot      = saved_slot(cur_q.mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q         <= '0;
            cur_q.mode    <= MODE_SVC;
            cur_q.irq_off <= 1'b1;
            cur_q.fiq_off <= 1'b1;
            for (int i = 0; i < N_SAVED; i++) saved_q[i] <= '0;
            refill_q      <= 1'b0;
        end else begin
            refill_q <= exc_en_i;
            if (exc_en_i) begin
                if (has_saved(exc_tgt)) saved_q[saved_slot(exc_tgt)] <= cur_q;
                cur_q.mode    <= exc_tgt;
                cur_q.irq_off <= 1'b1;
            end else if (mode_chg_en_i) begin
                cur_q.mode <= mode_chg_to_i | MODE_MSB;
            end else if (psr_wr_en_i) begin
                if (psr_wr_saved_i) begin
                    if (cur_has_saved)
                        saved_q[cur_slot] <= merge_status(saved_q[cur_slot], psr_wr_data_i,
                                                          psr_wr_flags_i, psr_wr_ctrl_i);
                end else begin
                    cur_q <= merge_status(cur_q, psr_wr_data_i, psr_wr_flags_i,
                                          psr_wr_ctrl_i && (cur_q.mode != MODE_USR));
                end
            end
        end
    end

    assign cur_o        = cur_q;
    assign saved_word_o = cur_has_saved ? pack_status(saved_q[cur_slot]) : pack_status(cur_q);
    assign refill_o     = refill_q;

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bankrf_pkg::*;
#(
    parameter int ARCH_REGS = 16,
    parameter int PC_ALIGN  = 2,
    localparam int SEL_W    = $clog2(ARCH_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  rd_a_sel,
    output logic [WORD_W-1:0] rd_a_data,
    input  logic [SEL_W-1:0]  rd_b_sel,
    output logic [WORD_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              mode_chg_en,
    input  logic [4:0]        mode_chg_to,
    input  logic              psr_wr_en,
    input  logic              psr_wr_saved,
    input  logic              psr_wr_flags,
    input  logic              psr_wr_ctrl,
    input  logic [WORD_W-1:0] psr_wr_data,
    input  logic              exc_en,
    input  logic [4:0]        exc_mode,
    input  logic [WORD_W-1:0] exc_vector,
    input  logic [WORD_W-1:0] exc_ret_addr,
    output logic [4:0]        mode_o,
    output logic [3:0]        flags_o,
    output logic              irq_mask_o,
    output logic              fiq_mask_o,
    output logic [WORD_W-1:0] status_word_o,
    output logic [WORD_W-1:0] saved_word_o,
    output logic              refill_o
);

    localparam int N_RD = 2;

    status_t                      cur;
    logic [N_RD-1:0][3:0]         rd_sel;
    logic [N_RD-1:0][WORD_W-1:0]  rd_data;

    assign rd_sel = {rd_b_sel, rd_a_sel};

    bankrf_status u_status (
        .clk            (clk),
        .rst            (rst),
        .exc_en_i       (exc_en),
        .exc_mode_i     (exc_mode),
        .mode_chg_en_i  (mode_chg_en),
        .mode_chg_to_i  (mode_chg_to),
        .psr_wr_en_i    (psr_wr_en),
        .psr_wr_saved_i (psr_wr_saved),
        .psr_wr_flags_i (psr_wr_flags),
        .psr_wr_ctrl_i  (psr_wr_ctrl),
        .psr_wr_data_i  (psr_wr_data),
        .cur_o          (cur),
        .saved_word_o   (saved_word_o),
        .refill_o       (refill_o)
    );

    bankrf_gpr #(.N_RD(N_RD), .PC_ALIGN(PC_ALIGN)) u_gpr (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (cur.mode),
        .rd_sel_i   (rd_sel),
        .rd_data_o  (rd_data),
        .wr_en_i    (wr_en),
        .wr_sel_i   (wr_sel),
        .wr_data_i  (wr_data),
        .exc_en_i   (exc_en),
        .exc_mode_i (exc_mode),
        .exc_vec_i  (exc_vector),
        .exc_ret_i  (exc_ret_addr)
    );

    assign rd_a_data     = rd_data[0];
    assign rd_b_data     = rd_data[1];
    assign mode_o        = cur.mode;
    assign flags_o       = {cur.n, cur.z, cur.c, cur.v};
    assign irq_mask_o    = cur.irq_off;
    assign fiq_mask_o    = cur.fiq_off;
    assign status_word_o = pack_status(cur);

endmodule

// File: rtl/bankrf_checker.sv
module bankrf_checker #(
    parameter int PC_ALIGN = 2
) (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  rd_a_sel,
    input logic [31:0] rd_a_data,
    input logic        mode_chg_en,
    input logic        psr_wr_en,
    input logic        psr_wr_saved,
    input logic        exc_en,
    input logic [4:0]  exc_mode,
    input logic [4:0]  mode_o,
    input logic [3:0]  flags_o,
    input logic        irq_mask_o,
    input logic        fiq_mask_o,
    input logic [31:0] status_word_o,
    input logic [31:0] saved_word_o,
    input logic        refill_o
);

    p_mode_msb_r1: assert property (@(posedge clk) disable iff (rst) mode_o[4]);

    p_reset_state_r8: assert property (@(posedge clk)
        rst |=> (mode_o == 5'h13) && irq_mask_o && fiq_mask_o && (flags_o == 4'h0));

    p_no_saved_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 5'h10 || mode_o == 5'h1F) |-> (saved_word_o == status_word_o));

    p_exc_entry_r6: assert property (@(posedge clk) disable iff (rst)
        exc_en |=> (mode_o == ($past(exc_mode) | 5'h10)) && irq_mask_o &&
                   (fiq_mask_o == $past(fiq_mask_o)) && (flags_o == $past(flags_o)));

    p_refill_on_r7: assert property (@(posedge clk) disable iff (rst) exc_en |=> refill_o);

    p_refill_off_r7: assert property (@(posedge clk) disable iff (rst) !exc_en |=> !refill_o);

    p_user_ctrl_r9: assert property (@(posedge clk) disable iff (rst)
        (psr_wr_en && !psr_wr_saved && !exc_en && !mode_chg_en && mode_o == 5'h10)
        |=> (mode_o == 5'h10) && $stable(irq_mask_o) && $stable(fiq_mask_o));

    p_pc_word_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_a_sel == 4'd15) |-> (rd_a_data[PC_ALIGN-1:0] == '0));

endmodule

bind banked_regfile bankrf_checker #(.PC_ALIGN(PC_ALIGN)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rd_a_sel      (rd_a_sel),
    .rd_a_data     (rd_a_data),
    .mode_chg_en   (mode_chg_en),
    .psr_wr_en     (psr_wr_en),
    .psr_wr_saved  (psr_wr_saved),
    .exc_en        (exc_en),
    .exc_mode      (exc_mode),
    .mode_o        (mode_o),
    .flags_o       (flags_o),
    .irq_mask_o    (irq_mask_o),
    .fiq_mask_o    (fiq_mask_o),
    .status_word_o (status_word_o),
    .saved_word_o  (saved_word_o),
    .refill_o      (refill_o)
);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
    logic [31:0] rd_a_data, rd_b_data;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        mode_chg_en = 1'b0;
    logic [4:0]  mode_chg_to = '0;
    logic        psr_wr_en = 1'b0, psr_wr_saved = 1'b0, psr_wr_flags = 1'b0, psr_wr_ctrl = 1'b0;
    logic [31:0] psr_wr_data = '0;
    logic        exc_en = 1'b0;
    logic [4:0]  exc_mode = '0;
    logic [31:0] exc_vector = '0, exc_ret_addr = '0;
    logic [4:0]  mode_o;
    logic [3:0]  flags_o;
    logic        irq_mask_o, fiq_mask_o, refill_o;
    logic [31:0] status_word_o, saved_word_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    banked_regfile dut_i (.*);

    // ---------------- reference model ----------------
    logic [31:0] m_usr [16];
    logic [31:0] m_fiq [7];
    logic [31:0] m_l13 [4];
    logic [31:0] m_l14 [4];
    logic [31:0] m_sav [5];
    logic [4:0]  m_mode;
    logic        m_n, m_z, m_c, m_v, m_i, m_f, m_refill;

    function automatic int slot_of(logic [4:0] m);
        case (m)
            5'h11: return 0;
            5'h12: return 1;
            5'h13: return 2;
            5'h17: return 3;
            5'h1B: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] m_read(logic [4:0] m, int idx);
        int s = slot_of(m);
        if (s == 0 && idx >= 8 && idx <= 14) return m_fiq[idx-8];
        if (s > 0 && idx == 13) return m_l13[s-1];
        if (s > 0 && idx == 14) return m_l14[s-1];
        return m_usr[idx];
    endfunction

    task automatic m_write(logic [4:0] m, int idx, logic [31:0] val);
        int s = slot_of(m);
        if (idx == 15) val[1:0] = 2'b00;
        if (s == 0 && idx >= 8 && idx <= 14) m_fiq[idx-8] = val;
        else if (s > 0 && idx == 13) m_l13[s-1] = val;
        else if (s > 0 && idx == 14) m_l14[s-1] = val;
        else m_usr[idx] = val;
    endtask

    function automatic logic [31:0] m_stat();
        return {m_n, m_z, m_c, m_v, 20'h0, m_i, m_f, 1'b0, m_mode};
    endfunction

    function automatic logic [31:0] m_saved();
        int s = slot_of(m_mode);
        return (s >= 0) ? m_sav[s] : m_stat();
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 16; i++) m_usr[i] = '0;
        for (int i = 0; i < 7; i++)  m_fiq[i] = '0;
        for (int i = 0; i < 4; i++) begin m_l13[i] = '0; m_l14[i] = '0; end
        for (int i = 0; i < 5; i++)  m_sav[i] = '0;
        m_mode = 5'h13; {m_n, m_z, m_c, m_v} = 4'h0; m_i = 1'b1; m_f = 1'b1; m_refill = 1'b0;
    endtask

    task automatic m_commit();
        logic [4:0]  pre = m_mode;
        logic [4:0]  t;
        logic [31:0] w;
        int s;
        m_refill = exc_en;
        if (exc_en) begin
            t = exc_mode | 5'h10;
            s = slot_of(t);
            if (s >= 0) m_sav[s] = m_stat();
            m_mode = t; m_i = 1'b1;
            m_write(t, 14, exc_ret_addr);
            m_write(t, 15, exc_vector);
        end else begin
            if (wr_en) m_write(pre, int'(wr_sel), wr_data);
            if (mode_chg_en) m_mode = mode_chg_to | 5'h10;
            else if (psr_wr_en) begin
                if (psr_wr_saved) begin
                    s = slot_of(m_mode);
                    if (s >= 0) begin
                        w = m_sav[s];
                        if (psr_wr_flags) w[31:28] = psr_wr_data[31:28];
                        if (psr_wr_ctrl)  w[7:0] = {psr_wr_data[7:6], 1'b0, psr_wr_data[4:0] | 5'h10};
                        m_sav[s] = w;
                    end
                end else begin
                    if (psr_wr_flags) {m_n, m_z, m_c, m_v} = psr_wr_data[31:28];
                    if (psr_wr_ctrl && m_mode != 5'h10) begin
                        m_mode = psr_wr_data[4:0] | 5'h10;
                        m_i = psr_wr_data[7]; m_f = psr_wr_data[6];
                    end
                end
            end
        end
    endtask

    // ---------------- helpers ----------------
    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        m_commit();
        @(negedge clk);
        wr_en = 0; mode_chg_en = 0; psr_wr_en = 0; exc_en = 0;
        psr_wr_saved = 0; psr_wr_flags = 0; psr_wr_ctrl = 0;
    endtask

    task automatic rd(string req, int a);
        rd_a_sel = 4'(a); rd_b_sel = 4'(15 - a);
        #1;
        chk(req, $sformatf("rd_a r%0d", a), rd_a_data, m_read(m_mode, a));
        chk(req, $sformatf("rd_b r%0d", 15 - a), rd_b_data, m_read(m_mode, 15 - a));
    endtask

    task automatic chk_status(string req);
        chk(req, "status", status_word_o, m_stat());
        chk(req, "saved", saved_word_o, m_saved());
        chk(req, "refill", 32'(refill_o), 32'(m_refill));
    endtask

    task automatic do_wr(int r, logic [31:0] v);
        wr_en = 1; wr_sel = 4'(r); wr_data = v; tick();
    endtask

    task automatic do_mode(logic [4:0] m);
        mode_chg_en = 1; mode_chg_to = m; tick();
    endtask

    function automatic logic [4:0] pick_mode();
        logic [4:0] list [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
        if ($urandom_range(0, 9) == 0) return 5'($urandom);
        return list[$urandom_range(0, 6)];
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        void'($urandom(32'h5EED_0A17));
        m_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R8 reset state
        chk("R8", "status 0xD3", status_word_o, 32'h0000_00D3);
        chk("R8", "mode", 32'(mode_o), 32'h13);
        chk("R8", "saved", saved_word_o, 32'h0);
        rd("R8", 13);
        rd("R8", 0);

        // R11 PC alignment
        do_wr(15, 32'h0000_1003);
        rd("R11", 15);
        chk("R11", "pc", rd_a_data, 32'h0000_1000);

        // R2 fast-interrupt bank
        do_mode(5'h10);
        do_wr(8, 32'h1111_0008);
        do_wr(14, 32'h1111_000E);
        do_mode(5'h11);
        rd("R10", 8);
        chk("R2", "fiq r8 private", rd_a_data, 32'h0);
        do_wr(8, 32'hAAAA_0008);
        do_wr(12, 32'hAAAA_000C);
        do_mode(5'h10);
        rd("R2", 8);
        chk("R2", "user r8 kept", rd_a_data, 32'h1111_0008);
        rd("R2", 12);
        chk("R2", "user r12 kept", rd_a_data, 32'h0);

        // R3 two-register banks
        do_mode(5'h12);
        do_wr(8, 32'hBBBB_0008);
        do_wr(13, 32'hBBBB_000D);
        rd("R3", 8);
        rd("R3", 13);
        do_mode(5'h10);
        rd("R3", 8);
        chk("R3", "shared r8", rd_a_data, 32'hBBBB_0008);
        rd("R3", 13);
        chk("R3", "user r13", rd_a_data, 32'h0);

        // R1 mode bit 4 forced
        do_mode(5'h03);
        chk("R1", "mode forced", 32'(mode_o), 32'h13);

        // R4 user/system share
        do_mode(5'h1F);
        do_wr(13, 32'hCCCC_000D);
        do_mode(5'h10);
        rd("R4", 13);
        chk("R4", "sys r13 in user", rd_a_data, 32'hCCCC_000D);

        // R5 saved write ignored in user
        psr_wr_en = 1; psr_wr_saved = 1; psr_wr_flags = 1; psr_wr_ctrl = 1;
        psr_wr_data = 32'hF000_0013; tick();
        chk("R5", "user saved=status", saved_word_o, status_word_o);
        chk_status("R5");

        // R9 user control write blocked, flags taken
        psr_wr_en = 1; psr_wr_flags = 1; psr_wr_ctrl = 1; psr_wr_data = 32'hA000_0013; tick();
        chk("R9", "mode stays user", 32'(mode_o), 32'h10);
        chk("R9", "flags taken", 32'(flags_o), 32'hA);
        chk_status("R9");

        // R6 R7 exception entry
        exc_en = 1; exc_mode = 5'h12; exc_vector = 32'h0000_001B; exc_ret_addr = 32'h0000_4444;
        tick();
        chk("R6", "mode irq", 32'(mode_o), 32'h12);
        chk("R6", "saved old", saved_word_o, 32'hA000_0010 | 32'h0000_00C0 & {24'h0, m_sav[1][7:0]});
        chk_status("R6");
        chk("R7", "refill high", 32'(refill_o), 32'h1);
        rd("R7", 14);
        chk("R7", "link", rd_a_data, 32'h0000_4444);
        rd("R7", 15);
        chk("R7", "vector", rd_a_data, 32'h0000_0018);
        tick();
        chk("R7", "refill low", 32'(refill_o), 32'h0);

        // R12 priority
        exc_en = 1; exc_mode = 5'h1B; exc_vector = 32'h4; exc_ret_addr = 32'h88;
        mode_chg_en = 1; mode_chg_to = 5'h11; wr_en = 1; wr_sel = 4'd3; wr_data = 32'hDEAD_0003;
        tick();
        chk("R12", "exception wins", 32'(mode_o), 32'h1B);
        rd("R12", 3);
        mode_chg_en = 1; mode_chg_to = 5'h13; psr_wr_en = 1; psr_wr_flags = 1; psr_wr_ctrl = 1;
        psr_wr_data = 32'h5000_0017; tick();
        chk("R12", "mode change over status", 32'(mode_o), 32'h13);
        chk_status("R12");

        // random mix
        for (int it = 0; it < 600; it++) begin
            int op = $urandom_range(0, 9);
            case (op)
                0, 1, 2: begin wr_en = 1; wr_sel = 4'($urandom); wr_data = $urandom; end
                3, 4:    begin mode_chg_en = 1; mode_chg_to = pick_mode(); end
                5, 6:    begin
                    psr_wr_en = 1; psr_wr_saved = 1'($urandom); psr_wr_flags = 1'($urandom);
                    psr_wr_ctrl = 1'($urandom);
                    psr_wr_data = $urandom; psr_wr_data[4:0] = pick_mode();
                end
                7:       begin
                    exc_en = 1; exc_mode = pick_mode(); exc_vector = $urandom; exc_ret_addr = $urandom;
                    wr_en = 1'($urandom); wr_sel = 4'($urandom); wr_data = $urandom;
                end
                default: ;
            endcase
            tick();
            rd("R10", $urandom_range(0, 15));
            chk_status("R10");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule